// File: doc/BRIEF.md
# Multi-Block Fetch Address Generator

This block turns one fetch address per cycle into the start addresses of up to three consecutive basic blocks. Internally it keeps a direct-mapped table. Each entry describes a two-level tree of branches. The first level is the branch that ends the first block, together with its taken and fall-through destinations. The second level has one branch on each side of the first, and each of those holds its own taken and fall-through destinations. The primary and secondary directions come from an external multiple-branch predictor, and they select one path through the tree. The blocks along that path are reported with a valid bit for each, together with the address for the next fetch.

One lookup is accepted per cycle, and its result appears on registered outputs one cycle later. Entries are written through a fill port, one whole entry per cycle. When a lookup misses, the block falls back to a plain sequential fetch: only the first block is reported, and the next fetch moves forward by one fetch step of 16 bytes. A branch of kind unconditional is always treated as taken, at either level.

Top module: `bac_fetch_gen`

## Requirements
- R1: `out_valid` is high in the cycle after a cycle in which `fetch_valid` was high, and low otherwise. When it is high, `blk0_addr` equals that fetch address and `blk_valid[0]` is 1.
- R2: On a miss, `blk_valid` is 3'b001 and `next_fetch_addr` is the fetch address plus 16. A miss is an empty slot or a tag mismatch.
- R3: On a hit to an entry whose primary valid bit is 1, the resolved primary direction picks `blk1_addr`. Taken gives the primary taken address and not-taken gives the primary fall-through address, and `blk_valid[1]` is 1.
- R4: If the side-branch valid bit on the chosen primary side is 1, the resolved secondary direction picks `blk2_addr` from that side's pair. Taken then taken gives TT, taken then not-taken gives TN, not-taken then taken gives NT, and not-taken then not-taken gives NN. `blk_valid[2]` is 1 and `next_fetch_addr` equals `blk2_addr`.
- R5: If the side-branch valid bit on the chosen side is 0, `blk_valid[2]` is 0 and `next_fetch_addr` is `blk1_addr` plus 16.
- R6: The branch kind codes are 2'd0 conditional, 2'd1 unconditional and 2'd2 return. Kind 1 makes that level taken whatever the prediction. Kinds 0 and 2 follow the prediction.
- R7: A hit to an entry whose primary valid bit is 0 gives the same result as a miss.
- R8: A fill writes the slot given by address bits [6:2]. It overwrites that slot and takes effect from the next cycle. A lookup in the same cycle as a fill to its slot returns the slot's previous contents.
- R9: Reset empties every slot, so lookups after reset miss even at addresses filled before. During reset, `out_valid` is 0.
- R10: Whenever `out_valid` is 1, any block whose valid bit is 0 reports address zero.
- R11: Every address bit outside [6:2] is part of the tag, so two addresses that share a slot but differ elsewhere do not match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fetch_valid | input | 1 | Lookup request this cycle |
| fetch_addr | input | 32 | Fetch address to look up |
| pred_primary | input | 1 | Predicted direction of the first-level branch (1 = taken) |
| pred_secondary | input | 1 | Predicted direction of the second-level branch (1 = taken) |
| fill_en | input | 1 | Write one entry this cycle |
| fill_addr | input | 32 | Address whose slot and tag are written |
| fill_prim_valid | input | 1 | A first-level branch exists |
| fill_prim_kind | input | 2 | Kind of the first-level branch |
| fill_tk_addr | input | 32 | First-level taken destination |
| fill_ft_addr | input | 32 | First-level fall-through destination |
| fill_tside_valid | input | 1 | A second-level branch exists on the taken side |
| fill_tside_kind | input | 2 | Kind of the taken-side second-level branch |
| fill_nside_valid | input | 1 | A second-level branch exists on the not-taken side |
| fill_nside_kind | input | 2 | Kind of the not-taken-side second-level branch |
| fill_tt_addr | input | 32 | Taken side, second-level taken destination |
| fill_tn_addr | input | 32 | Taken side, second-level fall-through destination |
| fill_nt_addr | input | 32 | Not-taken side, second-level taken destination |
| fill_nn_addr | input | 32 | Not-taken side, second-level fall-through destination |
| out_valid | output | 1 | Result of the previous cycle's lookup |
| blk0_addr | output | 32 | First block start |
| blk1_addr | output | 32 | Second block start |
| blk2_addr | output | 32 | Third block start |
| blk_valid | output | 3 | Valid bit for each block, bit i for block i |
| next_fetch_addr | output | 32 | Address for the following fetch |

## Verification
Every lookup result is due exactly one rising edge after the cycle in which the request was driven. The fill path is a single register stage, so a written entry is first visible to a lookup issued in the following cycle. The driver applies inputs on falling edges and puts one expected result into a queue for each request. The monitor looks at the outputs 2 ns after each rising edge and takes one entry from the queue whenever `out_valid` is high. A missing, extra or reordered result is therefore reported against the requirement that was expected.

// File: rtl/bac_pkg.sv
package bac_pkg;

  typedef enum logic [1:0] {
    BR_COND   = 2'd0,
    BR_UNCOND = 2'd1,
    BR_RET    = 2'd2,
    BR_RSVD   = 2'd3
  } br_kind_e;

  // Width of the packed per-entry flag field
  localparam int unsigned META_W = 9;

  // Resolved direction of one branch level
  function automatic logic resolve_dir(input logic [1:0] kind, input logic pred);
    return (kind == BR_UNCOND) ? 1'b1 : pred;
  endfunction

endpackage

// File: rtl/bac_table.sv
module bac_table #(
  parameter int unsigned ADDR_W  = 32,
  parameter int unsigned ENTRIES = 32,
  parameter int unsigned IDX_LSB = 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [bac_pkg::META_W-1:0] wr_meta,
  input  logic [ADDR_W-1:0]          wr_tk,
  input  logic [ADDR_W-1:0]          wr_ft,
  input  logic [ADDR_W-1:0]          wr_tt,
  input  logic [ADDR_W-1:0]          wr_tn,
  input  logic [ADDR_W-1:0]          wr_nt,
  input  logic [ADDR_W-1:0]          wr_nn,
  input  logic [ADDR_W-1:0]          rd_addr,
  output logic                       rd_hit,
  output logic [bac_pkg::META_W-1:0] rd_meta,
  output logic [ADDR_W-1:0]          rd_tk,
  output logic [ADDR_W-1:0]          rd_ft,
  output logic [ADDR_W-1:0]          rd_tt,
  output logic [ADDR_W-1:0]          rd_tn,
  output logic [ADDR_W-1:0]          rd_nt,
  output logic [ADDR_W-1:0]          rd_nn
);
  localparam int unsigned IDX_W  = $clog2(ENTRIES);
  localparam int unsigned TAG_W  = ADDR_W - IDX_W;
  localparam int unsigned HI_LSB = IDX_LSB + IDX_W;
  localparam int unsigned ROW_W  = TAG_W + bac_pkg::META_W + 6 * ADDR_W;

  // Tag is every address bit except the slot index
  function automatic logic [TAG_W-1:0] tag_of(input logic [ADDR_W-1:0] a);
    return {a[ADDR_W-1:HI_LSB], a[IDX_LSB-1:0]};
  endfunction

  logic [IDX_W-1:0]   wr_idx, rd_idx;
  logic [ROW_W-1:0]   wr_row, rd_row;
  logic [ROW_W-1:0]   rows [ENTRIES];
  logic [ENTRIES-1:0] vld_q, vld_d;
  logic [TAG_W-1:0]   rd_tag_stored;

  assign wr_idx = wr_addr[IDX_LSB +: IDX_W];
  assign rd_idx = rd_addr[IDX_LSB +: IDX_W];
  assign wr_row = {tag_of(wr_addr), wr_meta, wr_tk, wr_ft, wr_tt, wr_tn, wr_nt, wr_nn};

  // Slot valid bits: next state
  always_comb begin
    vld_d = vld_q;
    if (wr_en) begin
      vld_d[wr_idx] = 1'b1;
    end
  end

  // Slot valid bits: register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= '0;
    end else begin
      vld_q <= vld_d;
    end
  end

  // Entry payload, one register row per slot, written under a per-slot enable
  for (genvar e = 0; e < ENTRIES; e++) begin : g_row
    logic             row_we;
    logic [ROW_W-1:0] row_q;
    assign row_we = wr_en && (wr_idx == IDX_W'(e));
    always_ff @(posedge clk) begin
      if (row_we) begin
        row_q <= wr_row;
      end
    end
    assign rows[e] = row_q;
  end

  // Read side
  assign rd_row = rows[rd_idx];
  assign {rd_tag_stored, rd_meta, rd_tk, rd_ft, rd_tt, rd_tn, rd_nt, rd_nn} = rd_row;
  assign rd_hit = vld_q[rd_idx] && (rd_tag_stored == tag_of(rd_addr));

endmodule

// File: rtl/bac_path_sel.sv
module bac_path_sel #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 16
) (
  input  logic                       hit,
  input  logic [bac_pkg::META_W-1:0] meta,
  input  logic [ADDR_W-1:0]          fetch_addr,
  input  logic                       pred_p,
  input  logic                       pred_s,
  input  logic [ADDR_W-1:0]          tk,
  input  logic [ADDR_W-1:0]          ft,
  input  logic [ADDR_W-1:0]          tt,
  input  logic [ADDR_W-1:0]          tn,
  input  logic [ADDR_W-1:0]          nt,
  input  logic [ADDR_W-1:0]          nn,
  output logic [ADDR_W-1:0]          b0,
  output logic [ADDR_W-1:0]          b1,
  output logic [ADDR_W-1:0]          b2,
  output logic [2:0]                 bv,
  output logic [ADDR_W-1:0]          nxt
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  logic       p_valid, t_valid, n_valid;
  logic [1:0] p_kind, t_kind, n_kind;
  logic       p_dir, s_dir, side_valid;
  logic [1:0] side_kind;

  assign {p_valid, p_kind, t_valid, t_kind, n_valid, n_kind} = meta;

  always_comb begin
    p_dir      = bac_pkg::resolve_dir(p_kind, pred_p);
    side_valid = p_dir ? t_valid : n_valid;
    side_kind  = p_dir ? t_kind  : n_kind;
    s_dir      = bac_pkg::resolve_dir(side_kind, pred_s);

    b0  = fetch_addr;
    b1  = '0;
    b2  = '0;
    bv  = 3'b001;
    nxt = fetch_addr + STEP_V;

    if (hit && p_valid) begin
      b1    = p_dir ? tk : ft;
      bv[1] = 1'b1;
      if (side_valid) begin
        if (p_dir) begin
          b2 = s_dir ? tt : tn;
        end else begin
          b2 = s_dir ? nt : nn;
        end
        bv[2] = 1'b1;
        nxt   = b2;
      end else begin
        nxt = b1 + STEP_V;
      end
    end
  end

endmodule

// File: rtl/bac_fetch_gen.sv
module bac_fetch_gen #(
  parameter int unsigned ADDR_W     = 32,
  parameter int unsigned ENTRIES    = 32,
  parameter int unsigned IDX_LSB    = 2,
  parameter int unsigned FETCH_STEP = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fetch_valid,
  input  logic [ADDR_W-1:0] fetch_addr,
  input  logic              pred_primary,
  input  logic              pred_secondary,
  input  logic              fill_en,
  input  logic [ADDR_W-1:0] fill_addr,
  input  logic              fill_prim_valid,
  input  logic [1:0]        fill_prim_kind,
  input  logic [ADDR_W-1:0] fill_tk_addr,
  input  logic [ADDR_W-1:0] fill_ft_addr,
  input  logic              fill_tside_valid,
  input  logic [1:0]        fill_tside_kind,
  input  logic              fill_nside_valid,
  input  logic [1:0]        fill_nside_kind,
  input  logic [ADDR_W-1:0] fill_tt_addr,
  input  logic [ADDR_W-1:0] fill_tn_addr,
  input  logic [ADDR_W-1:0] fill_nt_addr,
  input  logic [ADDR_W-1:0] fill_nn_addr,
  output logic              out_valid,
  output logic [ADDR_W-1:0] blk0_addr,
  output logic [ADDR_W-1:0] blk1_addr,
  output logic [ADDR_W-1:0] blk2_addr,
  output logic [2:0]        blk_valid,
  output logic [ADDR_W-1:0] next_fetch_addr
);
  localparam int unsigned MW = bac_pkg::META_W;

  logic [MW-1:0]     wr_meta, rd_meta;
  logic              rd_hit;
  logic [ADDR_W-1:0] rd_tk, rd_ft, rd_tt, rd_tn, rd_nt, rd_nn;
  logic [ADDR_W-1:0] sel_b0, sel_b1, sel_b2, sel_nxt;
  logic [2:0]        sel_bv;

  logic              vld_d, vld_q;
  logic [2:0]        bv_d, bv_q;
  logic [ADDR_W-1:0] b0_d, b0_q, b1_d, b1_q, b2_d, b2_q, nxt_d, nxt_q;

  assign wr_meta = {fill_prim_valid, fill_prim_kind,
                    fill_tside_valid, fill_tside_kind,
                    fill_nside_valid, fill_nside_kind};

  bac_table #(
    .ADDR_W (ADDR_W),
    .ENTRIES(ENTRIES),
    .IDX_LSB(IDX_LSB)
  ) u_table (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (fill_en),
    .wr_addr(fill_addr),
    .wr_meta(wr_meta),
    .wr_tk  (fill_tk_addr),
    .wr_ft  (fill_ft_addr),
    .wr_tt  (fill_tt_addr),
    .wr_tn  (fill_tn_addr),
    .wr_nt  (fill_nt_addr),
    .wr_nn  (fill_nn_addr),
    .rd_addr(fetch_addr),
    .rd_hit (rd_hit),
    .rd_meta(rd_meta),
    .rd_tk  (rd_tk),
    .rd_ft  (rd_ft),
    .rd_tt  (rd_tt),
    .rd_tn  (rd_tn),
    .rd_nt  (rd_nt),
    .rd_nn  (rd_nn)
  );

  bac_path_sel #(
    .ADDR_W(ADDR_W),
    .STEP  (FETCH_STEP)
  ) u_path (
    .hit       (rd_hit),
    .meta      (rd_meta),
    .fetch_addr(fetch_addr),
    .pred_p    (pred_primary),
    .pred_s    (pred_secondary),
    .tk        (rd_tk),
    .ft        (rd_ft),
    .tt        (rd_tt),
    .tn        (rd_tn),
    .nt        (rd_nt),
    .nn        (rd_nn),
    .b0        (sel_b0),
    .b1        (sel_b1),
    .b2        (sel_b2),
    .bv        (sel_bv),
    .nxt       (sel_nxt)
  );

  // Output stage: next state
  always_comb begin
    vld_d = fetch_valid;
    bv_d  = bv_q;
    b0_d  = b0_q;
    b1_d  = b1_q;
    b2_d  = b2_q;
    nxt_d = nxt_q;
    if (fetch_valid) begin
      bv_d  = sel_bv;
      b0_d  = sel_b0;
      b1_d  = sel_b1;
      b2_d  = sel_b2;
      nxt_d = sel_nxt;
    end
  end

  // Output stage: control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q <= 1'b0;
      bv_q  <= '0;
    end else begin
      vld_q <= vld_d;
      bv_q  <= bv_d;
    end
  end

  // Output stage: address registers, no reset
  always_ff @(posedge clk) begin
    b0_q  <= b0_d;
    b1_q  <= b1_d;
    b2_q  <= b2_d;
    nxt_q <= nxt_d;
  end

  assign out_valid       = vld_q;
  assign blk_valid       = bv_q;
  assign blk0_addr       = b0_q;
  assign blk1_addr       = b1_q;
  assign blk2_addr       = b2_q;
  assign next_fetch_addr = nxt_q;

endmodule

// File: rtl/bac_fetch_gen_chk.sv
module bac_fetch_gen_chk #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned STEP   = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fetch_valid,
  input logic [ADDR_W-1:0] fetch_addr,
  input logic              out_valid,
  input logic [ADDR_W-1:0] blk0_addr,
  input logic [ADDR_W-1:0] blk1_addr,
  input logic [ADDR_W-1:0] blk2_addr,
  input logic [2:0]        blk_valid,
  input logic [ADDR_W-1:0] next_fetch_addr
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  p_latency_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> out_valid);

  p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !fetch_valid |=> !out_valid);

  p_first_blk_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_valid |=> (blk_valid[0] && blk0_addr == $past(fetch_addr)));

  p_seq_next_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !blk_valid[1]) |-> (next_fetch_addr == blk0_addr + STEP_V));

  p_third_next_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && blk_valid[2]) |-> (blk_valid[1] && next_fetch_addr == blk2_addr));

  p_ft_next_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && blk_valid[1] && !blk_valid[2]) |-> (next_fetch_addr == blk1_addr + STEP_V));

  p_zero_b1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !blk_valid[1]) |-> (blk1_addr == '0));

  p_zero_b2_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !blk_valid[2]) |-> (blk2_addr == '0));

endmodule

bind bac_fetch_gen bac_fetch_gen_chk #(
  .ADDR_W(ADDR_W),
  .STEP  (FETCH_STEP)
) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .fetch_valid    (fetch_valid),
  .fetch_addr     (fetch_addr),
  .out_valid      (out_valid),
  .blk0_addr      (blk0_addr),
  .blk1_addr      (blk1_addr),
  .blk2_addr      (blk2_addr),
  .blk_valid      (blk_valid),
  .next_fetch_addr(next_fetch_addr)
);

// File: tb/test_bac_fetch_gen.sv
module test_bac_fetch_gen;

  typedef struct packed {
    logic [31:0] addr;
    logic        pv;
    logic [1:0]  pk;
    logic [31:0] tk;
    logic [31:0] ft;
    logic        tv;
    logic [1:0]  tkd;
    logic        nv;
    logic [1:0]  nkd;
    logic [31:0] tt;
    logic [31:0] tn;
    logic [31:0] nt;
    logic [31:0] nn;
  } ent_t;

  typedef struct packed {
    logic [31:0] b0;
    logic [31:0] b1;
    logic [31:0] b2;
    logic [2:0]  v;
    logic [31:0] nxt;
  } exp_t;

  logic        clk, rst_n;
  logic        fetch_valid, pred_primary, pred_secondary;
  logic [31:0] fetch_addr;
  logic        fill_en, fill_prim_valid, fill_tside_valid, fill_nside_valid;
  logic [1:0]  fill_prim_kind, fill_tside_kind, fill_nside_kind;
  logic [31:0] fill_addr, fill_tk_addr, fill_ft_addr;
  logic [31:0] fill_tt_addr, fill_tn_addr, fill_nt_addr, fill_nn_addr;
  logic        out_valid;
  logic [31:0] blk0_addr, blk1_addr, blk2_addr, next_fetch_addr;
  logic [2:0]  blk_valid;

  int errors = 0;
  int checks = 0;
  bit done   = 0;

  exp_t  exp_q[$];
  string req_q[$];

  ent_t m_ent [32];
  bit   m_v   [32];

  bac_fetch_gen i_bac_fetch_gen (
    .clk             (clk),
    .rst_n           (rst_n),
    .fetch_valid     (fetch_valid),
    .fetch_addr      (fetch_addr),
    .pred_primary    (pred_primary),
    .pred_secondary  (pred_secondary),
    .fill_en         (fill_en),
    .fill_addr       (fill_addr),
    .fill_prim_valid (fill_prim_valid),
    .fill_prim_kind  (fill_prim_kind),
    .fill_tk_addr    (fill_tk_addr),
    .fill_ft_addr    (fill_ft_addr),
    .fill_tside_valid(fill_tside_valid),
    .fill_tside_kind (fill_tside_kind),
    .fill_nside_valid(fill_nside_valid),
    .fill_nside_kind (fill_nside_kind),
    .fill_tt_addr    (fill_tt_addr),
    .fill_tn_addr    (fill_tn_addr),
    .fill_nt_addr    (fill_nt_addr),
    .fill_nn_addr    (fill_nn_addr),
    .out_valid       (out_valid),
    .blk0_addr       (blk0_addr),
    .blk1_addr       (blk1_addr),
    .blk2_addr       (blk2_addr),
    .blk_valid       (blk_valid),
    .next_fetch_addr (next_fetch_addr)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // Reference model built from the requirements
  function automatic exp_t predict(input logic [31:0] a, input logic pp, input logic ps);
    exp_t       r;
    ent_t       e;
    logic       hit, pd, sv, sd;
    logic [1:0] sk;
    r.b0 = a; r.b1 = '0; r.b2 = '0; r.v = 3'b001; r.nxt = a + 32'd16;
    e   = m_ent[a[6:2]];
    hit = m_v[a[6:2]] && ((e.addr & ~32'h7C) == (a & ~32'h7C));
    if (hit && e.pv) begin
      pd = (e.pk == 2'd1) ? 1'b1 : pp;
      r.b1 = pd ? e.tk : e.ft;
      r.v[1] = 1'b1;
      sv = pd ? e.tv : e.nv;
      sk = pd ? e.tkd : e.nkd;
      if (sv) begin
        sd = (sk == 2'd1) ? 1'b1 : ps;
        r.b2 = pd ? (sd ? e.tt : e.tn) : (sd ? e.nt : e.nn);
        r.v[2] = 1'b1;
        r.nxt = r.b2;
      end else begin
        r.nxt = r.b1 + 32'd16;
      end
    end
    return r;
  endfunction

  task automatic drive_fill(input ent_t e);
    fill_en = 1'b1;          fill_addr = e.addr;
    fill_prim_valid = e.pv;  fill_prim_kind = e.pk;
    fill_tk_addr = e.tk;     fill_ft_addr = e.ft;
    fill_tside_valid = e.tv; fill_tside_kind = e.tkd;
    fill_nside_valid = e.nv; fill_nside_kind = e.nkd;
    fill_tt_addr = e.tt;     fill_tn_addr = e.tn;
    fill_nt_addr = e.nt;     fill_nn_addr = e.nn;
  endtask

  task automatic drive_lookup(input logic [31:0] a, input logic pp, input logic ps, input string req);
    exp_q.push_back(predict(a, pp, ps));
    req_q.push_back(req);
    fetch_valid = 1'b1; fetch_addr = a; pred_primary = pp; pred_secondary = ps;
  endtask

  // All tasks below start and end on a falling edge
  task automatic do_lookup(input logic [31:0] a, input logic pp, input logic ps, input string req);
    drive_lookup(a, pp, ps, req);
    @(negedge clk);
    fetch_valid = 1'b0;
  endtask

  task automatic do_fill(input ent_t e);
    drive_fill(e);
    @(negedge clk);
    fill_en = 1'b0;
    m_ent[e.addr[6:2]] = e;
    m_v[e.addr[6:2]]   = 1'b1;
  endtask

  task automatic do_fill_lookup(input ent_t e, input logic [31:0] a, input logic pp,
                                input logic ps, input string req);
    drive_fill(e);
    drive_lookup(a, pp, ps, req);
    @(negedge clk);
    fill_en = 1'b0; fetch_valid = 1'b0;
    m_ent[e.addr[6:2]] = e;
    m_v[e.addr[6:2]]   = 1'b1;
  endtask

  task automatic check1(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    for (int i = 0; i < 32; i++) m_v[i] = 1'b0;
    @(negedge clk);
    check1(out_valid == 1'b0, "R9 out_valid during reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  // Monitor: compares each result against the queue head
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && out_valid) begin
        if (exp_q.size() == 0) begin
          check1(1'b0, "R1 unexpected result", blk0_addr, 32'd0);
        end else begin
          exp_t  x;
          string rq;
          x  = exp_q.pop_front();
          rq = req_q.pop_front();
          checks++;
          if (blk0_addr !== x.b0 || blk1_addr !== x.b1 || blk2_addr !== x.b2 ||
              blk_valid !== x.v || next_fetch_addr !== x.nxt) begin
            errors++;
            $display("FAIL %s actual b0=%h b1=%h b2=%h v=%b nxt=%h expected b0=%h b1=%h b2=%h v=%b nxt=%h",
                     rq, blk0_addr, blk1_addr, blk2_addr, blk_valid, next_fetch_addr,
                     x.b0, x.b1, x.b2, x.v, x.nxt);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    #2000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  localparam logic [31:0] A  = 32'h0000_1044;  // slot 17
  localparam logic [31:0] A2 = 32'h0000_10C4;  // slot 17, other tag
  localparam logic [31:0] B  = 32'h0000_2208;  // slot 2
  localparam logic [31:0] C  = 32'h0000_3310;  // slot 4
  localparam logic [31:0] D  = 32'h0000_4420;  // slot 8
  localparam logic [31:0] E  = 32'h0000_5530;  // slot 12

  initial begin
    ent_t ea, eb, ec, ed, ee, ea2;
    rst_n = 1'b0; fetch_valid = 1'b0; fetch_addr = '0; pred_primary = 1'b0; pred_secondary = 1'b0;
    fill_en = 1'b0; fill_addr = '0; fill_prim_valid = 1'b0; fill_prim_kind = '0;
    fill_tk_addr = '0; fill_ft_addr = '0; fill_tside_valid = 1'b0; fill_tside_kind = '0;
    fill_nside_valid = 1'b0; fill_nside_kind = '0;
    fill_tt_addr = '0; fill_tn_addr = '0; fill_nt_addr = '0; fill_nn_addr = '0;
    for (int i = 0; i < 32; i++) m_v[i] = 1'b0;

    ea  = '{addr:A, pv:1, pk:2'd0, tk:32'h2000, ft:32'h1050, tv:1, tkd:2'd0, nv:1, nkd:2'd0,
            tt:32'h3000, tn:32'h2010, nt:32'h4000, nn:32'h1060};
    eb  = '{addr:B, pv:1, pk:2'd0, tk:32'h6000, ft:32'h2218, tv:0, tkd:2'd0, nv:1, nkd:2'd0,
            tt:32'h0, tn:32'h0, nt:32'h6100, nn:32'h2230};
    ec  = '{addr:C, pv:1, pk:2'd1, tk:32'h7000, ft:32'h3320, tv:1, tkd:2'd1, nv:1, nkd:2'd0,
            tt:32'h7100, tn:32'h7010, nt:32'h7200, nn:32'h3330};
    ed  = '{addr:D, pv:0, pk:2'd0, tk:32'h8000, ft:32'h4430, tv:1, tkd:2'd0, nv:1, nkd:2'd0,
            tt:32'h8100, tn:32'h8010, nt:32'h8200, nn:32'h4440};
    ee  = '{addr:E, pv:1, pk:2'd2, tk:32'h9000, ft:32'h5540, tv:1, tkd:2'd0, nv:1, nkd:2'd2,
            tt:32'h9100, tn:32'h9010, nt:32'h9200, nn:32'h5550};
    ea2 = '{addr:A, pv:1, pk:2'd0, tk:32'hA000, ft:32'h1054, tv:0, tkd:2'd0, nv:0, nkd:2'd0,
            tt:32'h0, tn:32'h0, nt:32'h0, nn:32'h0};

    @(negedge clk);
    @(negedge clk);
    check1(out_valid == 1'b0, "R9 out_valid in reset", 32'(out_valid), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    do_lookup(A, 1'b1, 1'b1, "R2 miss on empty slot");
    do_fill(ea);
    do_lookup(A, 1'b1, 1'b1, "R4 path TT");
    do_lookup(A, 1'b1, 1'b0, "R4 path TN");
    do_lookup(A, 1'b0, 1'b1, "R4 path NT");
    do_lookup(A, 1'b0, 1'b0, "R3 R4 path NN");
    do_fill(eb);
    do_lookup(B, 1'b1, 1'b1, "R5 no taken-side branch");
    do_lookup(B, 1'b0, 1'b1, "R3 not-taken side present");
    do_fill(ec);
    do_lookup(C, 1'b0, 1'b0, "R6 unconditional both levels");
    do_fill(ee);
    do_lookup(E, 1'b0, 1'b1, "R6 return kind follows prediction");
    do_lookup(E, 1'b1, 1'b0, "R6 conditional second level");
    do_fill(ed);
    do_lookup(D, 1'b1, 1'b1, "R7 primary invalid acts as miss");
    do_lookup(A2, 1'b1, 1'b1, "R11 alias with other tag");
    do_lookup(A + 32'h0000_1000, 1'b0, 1'b0, "R11 high tag bit differs");
    do_fill_lookup(ea2, A, 1'b1, 1'b1, "R8 same-cycle lookup sees old entry");
    do_lookup(A, 1'b1, 1'b1, "R8 new entry visible next cycle");
    @(negedge clk);
    @(negedge clk);
    check1(out_valid == 1'b0, "R1 idle result", 32'(out_valid), 32'd0);
    do_reset();
    do_lookup(C, 1'b1, 1'b1, "R9 miss after reset");
    @(negedge clk);
    @(negedge clk);
    check1(exp_q.size() == 0, "R1 all results delivered", 32'(exp_q.size()), 32'd0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule